// File: doc/BRIEF.md
# Option Instruction Group Dispatcher

This block sits in the decode path of a 16-bit processor. It looks at an instruction word and decides which execution engine should receive it: the extended arithmetic unit, or one of twelve optional firmware instruction sets. It uses the upper byte of the word to find the instruction group and bits 7-4 to find the module inside a user group. Bits 3-0, the entry point inside the chosen module, pass through in the forwarded word. The outcome also depends on which CPU model is configured and on which options are installed. The block flags a trap when nothing may legally receive the instruction.

The decode is purely combinational. One register stage captures the select vector, the forwarded word, the group code and the trap and no-op flags, so every result shows up one clock after the inputs were sampled. One option range is relocated before it is forwarded: the instruction word is XORed with a fixed constant so that the receiving module sees its native code points.

Top module: `odsp_dispatch`

## Requirements
- R1: While reset is asserted and after it is released, before the first sampled input, `sel_o`, `trap_o` and `nop_o` are zero, `group_o` is 0 and `word_o` is 0.
- R2: `group_o` is 1 (arithmetic) for upper bytes octal 200, 201, 202, 210 and 211. It is 2 (user group 0) for 212 and 3 (user group 1) for 203 and 213. Every other upper byte gives 0, with no select, no trap and no no-op.
- R3: In user group 0, bits 7-4 choose the target. Values 0-5 choose floating point (sel bit 1) and 8-9 fast FORTRAN (bit 2). Value 10 chooses extended memory (bit 3), 12 distributed system (bit 4) and 14 OS assist (bit 7). Value 13 chooses scientific (bit 5) when the model is F (code 3) and double integer (bit 6) otherwise.
- R4: In user group 1, bits 7-4 choose the target. Values 0-1 choose the I/O processor (bit 8). Value 3 chooses vector (bit 9) on model F and the I/O processor otherwise. Value 8 chooses signal processing (bit 10), 12-13 memory mapping (bit 11) and 14-15 the extended instruction group (bit 12).
- R5: An arithmetic-group word selects sel bit 0 when option enable bit 0 is set.
- R6: With enable bit 0 clear, an arithmetic-group word raises `trap_o`. The one exception is word octal 101100 on the small model (code 0), which raises `nop_o` instead.
- R7: On the small model with enable bit 8 set, every user-group-0 word selects the I/O processor (bit 8), whatever bits 7-4 hold.
- R8: A user-group-1 word traps when the model is the small model (code 0).
- R9: A user-group-1 word with bits 7-4 equal to 5 selects distributed system (bit 4) and is forwarded XORed with octal 000620. Every other word is forwarded unchanged.
- R10: A user-group word whose module has no mapping, or whose target's enable bit is clear, raises `trap_o` with no select bit. Enable bit i gates sel bit i.
- R11: Each output reflects the inputs sampled at the previous rising clock edge and does not change between edges.
- R12: `sel_o` has at most one bit set, and `sel_o`, `trap_o` and `nop_o` are never active together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, rising edge |
| rst_ni | input | 1 | Active-low synchronous reset |
| instr_i | input | 16 | Instruction word to classify |
| model_i | input | 2 | CPU model: 0 small, 1 M, 2 E, 3 F |
| opt_en_i | input | 13 | Installed-option enables, bit i gates target i |
| sel_o | output | 13 | One-hot target select (bit 0 arithmetic ... bit 12 extended group) |
| word_o | output | 16 | Forwarded, possibly remapped, instruction word |
| group_o | output | 2 | Group code: 0 none, 1 arithmetic, 2 user 0, 3 user 1 |
| trap_o | output | 1 | Undefined-instruction trap |
| nop_o | output | 1 | Instruction is treated as a no-op |

## Verification
The bench builds the block with its default word width of 16 and all 13 targets. At that size every model code, every module nibble of every group byte and every single-option-removed enable pattern can be swept together, along with the all-on and all-off patterns. This reaches each model-dependent choice, the forced I/O processor routing and each disabled-target trap. A second sweep covers all 256 upper bytes, and directed vectors cover the small-model arithmetic no-op and its near neighbours.

// File: rtl/odsp_pkg.sv
package odsp_pkg;

    localparam int WORD_W  = 16;
    localparam int MOD_W   = 4;
    localparam int TGT_N   = 13;

    // target indices: select bit i and enable bit i belong together
    localparam int T_ARITH = 0;
    localparam int T_FLOAT = 1;
    localparam int T_FFORT = 2;
    localparam int T_XMEM  = 3;
    localparam int T_DSYS  = 4;
    localparam int T_SCI   = 5;
    localparam int T_DINT  = 6;
    localparam int T_OSAS  = 7;
    localparam int T_IOP   = 8;
    localparam int T_VEC   = 9;
    localparam int T_SIG   = 10;
    localparam int T_MMAP  = 11;
    localparam int T_XIG   = 12;

    localparam logic [WORD_W-1:0] REMAP_XOR = 16'o000620;
    localparam logic [WORD_W-1:0] SMALL_NOP = 16'o101100;

    typedef enum logic [1:0] {
        MDL_SMALL = 2'd0,
        MDL_M     = 2'd1,
        MDL_E     = 2'd2,
        MDL_F     = 2'd3
    } model_e;

    typedef enum logic [1:0] {
        GRP_NONE  = 2'd0,
        GRP_ARITH = 2'd1,
        GRP_UG0   = 2'd2,
        GRP_UG1   = 2'd3
    } group_e;

    typedef logic [TGT_N-1:0] tgt_vec_t;

    typedef struct packed {
        tgt_vec_t          sel;
        logic [WORD_W-1:0] word;
        group_e            grp;
        logic              trap;
        logic              nop;
    } disp_t;

    function automatic tgt_vec_t tgt_bit(input int idx);
        tgt_vec_t v;
        v = '0;
        v[idx] = 1'b1;
        return v;
    endfunction

endpackage

// File: rtl/odsp_group_classify.sv
module odsp_group_classify
    import odsp_pkg::*;
(
    input  logic [7:0] op_hi_i,
    output group_e     grp_o
);
    always_comb begin
        unique case (op_hi_i)
            8'o200, 8'o201, 8'o202,
            8'o210, 8'o211:        grp_o = GRP_ARITH;
            8'o212:                grp_o = GRP_UG0;
            8'o203, 8'o213:        grp_o = GRP_UG1;
            default:               grp_o = GRP_NONE;
        endcase
    end
endmodule

// File: rtl/odsp_ug0_map.sv
module odsp_ug0_map
    import odsp_pkg::*;
(
    input  logic [MOD_W-1:0] mod_i,
    input  model_e           model_i,
    output tgt_vec_t         want_o
);
    always_comb begin
        want_o = '0;
        unique case (mod_i)
            4'd0, 4'd1, 4'd2,
            4'd3, 4'd4, 4'd5:  want_o = tgt_bit(T_FLOAT);
            4'd8, 4'd9:        want_o = tgt_bit(T_FFORT);
            4'd10:             want_o = tgt_bit(T_XMEM);
            4'd12:             want_o = tgt_bit(T_DSYS);
            4'd13:             want_o = (model_i == MDL_F) ? tgt_bit(T_SCI)
                                                           : tgt_bit(T_DINT);
            4'd14:             want_o = tgt_bit(T_OSAS);
            default:           want_o = '0;
        endcase
    end
endmodule

// File: rtl/odsp_ug1_map.sv
module odsp_ug1_map
    import odsp_pkg::*;
(
    input  logic [MOD_W-1:0] mod_i,
    input  model_e           model_i,
    output tgt_vec_t         want_o,
    output logic             remap_o
);
    always_comb begin
        want_o  = '0;
        remap_o = 1'b0;
        unique case (mod_i)
            4'd0, 4'd1:   want_o = tgt_bit(T_IOP);
            4'd3:         want_o = (model_i == MDL_F) ? tgt_bit(T_VEC)
                                                      : tgt_bit(T_IOP);
            4'd5: begin
                          want_o  = tgt_bit(T_DSYS);
                          remap_o = 1'b1;
            end
            4'd8:         want_o = tgt_bit(T_SIG);
            4'd12, 4'd13: want_o = tgt_bit(T_MMAP);
            4'd14, 4'd15: want_o = tgt_bit(T_XIG);
            default:      want_o = '0;
        endcase
    end
endmodule

// File: rtl/odsp_opt_gate.sv
module odsp_opt_gate #(
    parameter int N = 13
) (
    input  logic [N-1:0] want_i,
    input  logic [N-1:0] en_i,
    output logic [N-1:0] grant_o,
    output logic         blocked_o
);
    for (genvar g = 0; g < N; g++) begin : g_bit
        assign grant_o[g] = want_i[g] & en_i[g];
    end
    assign blocked_o = (grant_o == '0);
endmodule

// File: rtl/odsp_dispatch.sv
module odsp_dispatch
    import odsp_pkg::*;
(
    input  logic                  clk_i,
    input  logic                  rst_ni,
    input  logic [WORD_W-1:0]     instr_i,
    input  logic [1:0]            model_i,
    input  logic [TGT_N-1:0]      opt_en_i,
    output logic [TGT_N-1:0]      sel_o,
    output logic [WORD_W-1:0]     word_o,
    output logic [1:0]            group_o,
    output logic                  trap_o,
    output logic                  nop_o
);
    localparam int MOD_LSB = MOD_W;

    model_e            model_w;
    group_e            grp_w;
    logic [MOD_W-1:0]  mod_w;
    tgt_vec_t          ug0_want_w, ug1_want_w, want_w, grant_w;
    logic              ug1_remap_w, blocked_w;
    logic              small_w;

    disp_t             disp_d, disp_q;
    logic              seen_d, seen_q;

    assign model_w = model_e'(model_i);
    assign mod_w   = instr_i[MOD_LSB +: MOD_W];
    assign small_w = (model_w == MDL_SMALL);

    odsp_group_classify i_grp (
        .op_hi_i (instr_i[WORD_W-1 -: 8]),
        .grp_o   (grp_w)
    );

    odsp_ug0_map i_ug0 (
        .mod_i   (mod_w),
        .model_i (model_w),
        .want_o  (ug0_want_w)
    );

    odsp_ug1_map i_ug1 (
        .mod_i   (mod_w),
        .model_i (model_w),
        .want_o  (ug1_want_w),
        .remap_o (ug1_remap_w)
    );

    // requested target before the enables are applied
    always_comb begin
        want_w = '0;
        unique case (grp_w)
            GRP_ARITH: want_w = tgt_bit(T_ARITH);
            GRP_UG0:   want_w = (small_w && opt_en_i[T_IOP]) ? tgt_bit(T_IOP)
                                                             : ug0_want_w;
            GRP_UG1:   want_w = small_w ? '0 : ug1_want_w;
            default:   want_w = '0;
        endcase
    end

    odsp_opt_gate #(.N(TGT_N)) i_gate (
        .want_i    (want_w),
        .en_i      (opt_en_i),
        .grant_o   (grant_w),
        .blocked_o (blocked_w)
    );

    always_comb begin
        disp_d      = '0;
        disp_d.grp  = grp_w;
        disp_d.word = instr_i;
        seen_d      = 1'b1;
        unique case (grp_w)
            GRP_ARITH: begin
                if (!opt_en_i[T_ARITH] && small_w && instr_i == SMALL_NOP) begin
                    disp_d.nop = 1'b1;
                end else begin
                    disp_d.sel  = grant_w;
                    disp_d.trap = blocked_w;
                end
            end
            GRP_UG0: begin
                disp_d.sel  = grant_w;
                disp_d.trap = blocked_w;
            end
            GRP_UG1: begin
                disp_d.sel  = grant_w;
                disp_d.trap = blocked_w;
                if (ug1_remap_w) begin
                    disp_d.word = instr_i ^ REMAP_XOR;
                end
            end
            default: begin
                disp_d.sel  = '0;
            end
        endcase
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            disp_q <= '{sel: '0, word: '0, grp: GRP_NONE, trap: 1'b0, nop: 1'b0};
            seen_q <= 1'b0;
        end else begin
            disp_q <= disp_d;
            seen_q <= seen_d;
        end
    end

    assign sel_o   = disp_q.sel;
    assign word_o  = disp_q.word;
    assign group_o = disp_q.grp;
    assign trap_o  = disp_q.trap;
    assign nop_o   = disp_q.nop;

    // R12: at most one target
    assert_sel_onehot_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $onehot0(sel_o));

    // R12: select, trap and no-op exclusive
    assert_flags_exclusive_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $countones({|sel_o, trap_o, nop_o}) <= 1);

    // R2: words outside every group stay quiet
    assert_none_quiet_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (group_o == 2'd0) |-> (sel_o == '0 && !trap_o && !nop_o));

    // R8: user group 1 on the small model traps
    assert_ug1_small_trap_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (seen_q && $past(model_i == 2'd0 &&
            (instr_i[15:8] == 8'o203 || instr_i[15:8] == 8'o213))) |-> trap_o);

    // R10: a disabled option is never selected
    assert_disabled_unselected_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
        seen_q |-> ((sel_o & ~$past(opt_en_i)) == '0));

    // R9: only the relocated range changes the forwarded word
    assert_word_pass_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (seen_q && $past(instr_i[7:4] != 4'd5)) |-> (word_o == $past(instr_i)));

endmodule

// File: tb/test_odsp_dispatch.sv
module test_odsp_dispatch;
    localparam int CLK_PERIOD = 10;
    localparam int NT = 13;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [15:0]   instr = '0;
    logic [1:0]    model = '0;
    logic [NT-1:0] en = '0;
    logic [NT-1:0] sel;
    logic [15:0]   word;
    logic [1:0]    grp;
    logic          trap, nop;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 1'b0;

    typedef struct packed {
        logic [NT-1:0] sel;
        logic [15:0]   word;
        logic [1:0]    grp;
        logic          trap;
        logic          nop;
    } exp_t;

    exp_t  prev_e;

    always #(CLK_PERIOD/2) clk = ~clk;

    odsp_dispatch i_odsp_dispatch (
        .clk_i    (clk),
        .rst_ni   (rst_n),
        .instr_i  (instr),
        .model_i  (model),
        .opt_en_i (en),
        .sel_o    (sel),
        .word_o   (word),
        .group_o  (grp),
        .trap_o   (trap),
        .nop_o    (nop)
    );

    task automatic predict(input logic [15:0] w, input logic [1:0] m,
                           input logic [NT-1:0] e, output exp_t r, output string tag);
        int tgt;
        logic [3:0] md;
        md  = w[7:4];
        r   = '0;
        r.word = w;
        tgt = -1;
        tag = "R2";
        case (w[15:8])
            8'o200, 8'o201, 8'o202, 8'o210, 8'o211: r.grp = 2'd1;
            8'o212:                                 r.grp = 2'd2;
            8'o203, 8'o213:                         r.grp = 2'd3;
            default:                                r.grp = 2'd0;
        endcase
        if (r.grp == 2'd1) begin
            if (e[0]) begin tgt = 0; tag = "R5"; end
            else if (m == 2'd0 && w == 16'o101100) begin r.nop = 1'b1; tag = "R6"; end
            else begin r.trap = 1'b1; tag = "R6"; end
        end else if (r.grp == 2'd2) begin
            tag = "R3";
            if (m == 2'd0 && e[8]) begin tgt = 8; tag = "R7"; end
            else if (md <= 4'd5) tgt = 1;
            else if (md == 4'd8 || md == 4'd9) tgt = 2;
            else if (md == 4'd10) tgt = 3;
            else if (md == 4'd12) tgt = 4;
            else if (md == 4'd13) tgt = (m == 2'd3) ? 5 : 6;
            else if (md == 4'd14) tgt = 7;
            else begin r.trap = 1'b1; tag = "R10"; end
        end else if (r.grp == 2'd3) begin
            tag = "R4";
            if (md == 4'd5) begin r.word = w ^ 16'o000620; tag = "R9"; end
            if (m == 2'd0) begin r.trap = 1'b1; tag = "R8"; end
            else if (md <= 4'd1) tgt = 8;
            else if (md == 4'd3) tgt = (m == 2'd3) ? 9 : 8;
            else if (md == 4'd5) tgt = 4;
            else if (md == 4'd8) tgt = 10;
            else if (md >= 4'd12 && md <= 4'd13) tgt = 11;
            else if (md >= 4'd14) tgt = 12;
            else begin r.trap = 1'b1; tag = "R10"; end
        end
        if (tgt >= 0) begin
            if (e[tgt]) r.sel[tgt] = 1'b1;
            else begin r.trap = 1'b1; tag = "R10"; end
        end
    endtask

    task automatic compare(input exp_t x, input string tag);
        exp_t a;
        a = '{sel: sel, word: word, grp: grp, trap: trap, nop: nop};
        n_tests++;
        if (a !== x) begin
            n_fail++;
            $display("FAIL %s instr=%o model=%0d: got sel=%b word=%o grp=%0d trap=%b nop=%b, expected sel=%b word=%o grp=%0d trap=%b nop=%b",
                     tag, instr, model, a.sel, a.word, a.grp, a.trap, a.nop,
                     x.sel, x.word, x.grp, x.trap, x.nop);
        end
    endtask

    // called just after a falling edge
    task automatic step(input logic [15:0] w, input logic [1:0] m, input logic [NT-1:0] e);
        exp_t  x;
        string tag;
        instr = w; model = m; en = e;
        #1;
        compare(prev_e, "R11");     // R11: no change before the edge
        predict(w, m, e, x, tag);
        @(posedge clk);
        @(negedge clk);
        compare(x, tag);
        prev_e = x;
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        if (!done) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog: got hang, expected completion");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        logic [7:0] his [10];
        his = '{8'o200, 8'o201, 8'o202, 8'o203, 8'o210,
                8'o211, 8'o212, 8'o213, 8'o204, 8'o105};
        instr = 16'o105320; model = 2'd3; en = '1;
        repeat (3) @(negedge clk);
        prev_e = '0;
        compare(prev_e, "R1");      // R1: outputs held at reset
        rst_n = 1'b1;
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        compare(prev_e, "R1");
        rst_n = 1'b1;

        // main sweep: models x group bytes x modules x enable patterns
        for (int m = 0; m < 4; m++) begin
            for (int h = 0; h < 10; h++) begin
                for (int md = 0; md < 16; md++) begin
                    for (int p = 0; p < 15; p++) begin
                        logic [NT-1:0] ep;
                        logic [3:0]    lo;
                        if (p == 0)       ep = '1;
                        else if (p == 14) ep = '0;
                        else begin ep = '1; ep[p-1] = 1'b0; end
                        lo = 4'((md * 5 + m + p) & 15);
                        step({his[h], 4'(md), lo}, 2'(m), ep);
                    end
                end
            end
        end

        // R2: every upper byte
        for (int b = 0; b < 256; b++) begin
            step({8'(b), 4'(b & 15), 4'((b >> 4) & 15)}, 2'd2, '1);
        end

        // R6: small-model no-op and neighbours
        step(16'o101100, 2'd0, 13'h1FFE);
        step(16'o101101, 2'd0, 13'h1FFE);
        step(16'o101100, 2'd1, 13'h1FFE);
        step(16'o101100, 2'd0, '1);
        // R7: forced routing covers unmapped group-0 modules too
        step(16'o105260, 2'd0, 13'h0100);
        step(16'o105260, 2'd1, 13'h0100);
        // R9: relocation round trip
        step(16'o105527, 2'd2, 13'h0010);
        step(16'o101537, 2'd1, '1);

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule